// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block takes commands from a host over three wires: a serial clock, a serial data line and a strobe. Each command is a 9-bit frame. The frame's final bit selects one of two command registers. The volume register holds a 6-bit code for each of two channels, A and B. The control register holds a source-mode select, a boost enable, a power command, a mute command and two general-purpose port bits. A frame reaches its register only when the strobe rises after the frame has been shifted in.

All three serial wires are sampled by a faster system clock through two-flop synchronizers, and edges are found on the synchronized copies. The power command and the mute command are combined with two external pins to give the effective enables. Power is on only when both the command bit and the power pin are high. Mute is on when either the command bit or the mute pin is high. An active-low command-reset pin returns every command bit to its default value.

Top module: `ser_ctl_bank`

## Requirements
- R1: Frame layout. Bits arrive first bit first on rising serial-clock edges. After nine bits, the ninth bit is the address: 0 selects the volume register and 1 selects the control register.
- R2: Volume frame, single channel. Bit 1 enables the write to channel A and bit 2 enables the write to channel B. Bits 3 to 8 form the 6-bit code, with bit 3 as the LSB and bit 8 as the MSB. When bits 1 and 2 are both 0, neither channel changes.
- R3: Volume frame, both channels. When bits 1 and 2 are both 1, channels A and B both receive the same code.
- R4: Control frame. Bits 1 to 6 set, in this order: mode_sel, boost_en, the power command, the mute command, port_p1 and port_p2. Bits 7 and 8 have no effect.
- R5: A complete frame that is not followed by a strobe rising edge changes no output. Between strobes, every register output holds its value.
- R6: pwr_en is 1 only when the stored power command is 1 and the synchronized pwr_pin is 1.
- R7: mute_on is 1 when the stored mute command is 1 or the synchronized mute_pin is 1. If a command write and a pin change land in the same cycle, the output follows the OR of the two new values.
- R8: While cmd_rst_n is low, and also during rst, the outputs take their defaults: vol_a = vol_b = 63, mode_sel = 0, boost_en = 0, power command = 0 (so pwr_en = 0), mute command = 1 (so mute_on = 1), port_p1 = 1 and port_p2 = 0.
- R9: port_p1 and port_p2 drive the stored P1 and P2 bits directly: a stored 0 gives a low output and a stored 1 gives a high output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rst_n | input | 1 | Command reset, active low, asynchronous to clk |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| ser_stb | input | 1 | Strobe; its rising edge commits the shifted frame |
| pwr_pin | input | 1 | External power enable pin |
| mute_pin | input | 1 | External mute pin |
| vol_a | output | 6 | Channel A volume code |
| vol_b | output | 6 | Channel B volume code |
| mode_sel | output | 1 | Source mode select |
| boost_en | output | 1 | Low-frequency boost enable |
| pwr_en | output | 1 | Effective power enable (command AND pin) |
| mute_on | output | 1 | Effective mute (command OR pin) |
| port_p1 | output | 1 | General-purpose port 1 |
| port_p2 | output | 1 | General-purpose port 2 |

## Verification
Two functions can act in the same system-clock cycle: a strobe commit that rewrites the mute or power command, and a level change on the matching external pin. The pins and the strobe pass through synchronizers of equal depth. The bench therefore changes the pin on the same clock as the strobe's rising edge, so both changes reach the merge logic together. Pass or fail is judged by comparing the settled pwr_en and mute_on against the AND and OR of the newly written command bit and the new pin level.

// File: rtl/ser_ctl_pkg.sv
`timescale 1ns/1ps
package ser_ctl_pkg;

  typedef struct packed {
    logic mode;
    logic boost;
    logic pwr;
    logic mute;
    logic p1;
    logic p2;
  } ctl_t;

  localparam ctl_t CTL_DEFAULT = '{mode: 1'b0, boost: 1'b0, pwr: 1'b0,
                                   mute: 1'b1, p1: 1'b1, p2: 1'b0};

  localparam int CTL_FIELDS = 6;

endpackage

// File: rtl/ssync.sv
`timescale 1ns/1ps
module ssync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter #(
  parameter int FRAME_W = 9,
  parameter logic [FRAME_W-1:0] RST_FRAME = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               sck_s,
  input  logic               sdi_s,
  input  logic               stb_s,
  output logic [FRAME_W-1:0] frame,
  output logic               wr_pulse
);

  logic sck_d;
  logic stb_d;
  logic sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      stb_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      stb_d <= stb_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign wr_pulse = stb_s & ~stb_d;

  // first bit ends at index 0 after FRAME_W shifts
  always_ff @(posedge clk) begin
    if (rst || clr)    frame <= RST_FRAME;
    else if (sck_rise) frame <= {sdi_s, frame[FRAME_W-1:1]};
  end

endmodule

// File: rtl/ctl_regfile.sv
`timescale 1ns/1ps
module ctl_regfile
  import ser_ctl_pkg::*;
#(
  parameter int VOL_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_pulse,
  input  logic [VOL_W+2:0]   frame,
  input  logic               pwr_pin_s,
  input  logic               mute_pin_s,
  output logic [VOL_W-1:0]   vol_a,
  output logic [VOL_W-1:0]   vol_b,
  output ctl_t               ctl_q,
  output logic               pwr_en,
  output logic               mute_on
);

  localparam int FRAME_W  = VOL_W + 3;
  localparam int ADDR_BIT = FRAME_W - 1;
  localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

  logic             is_ctl;
  logic             wr_a;
  logic             wr_b;
  logic [VOL_W-1:0] code;
  ctl_t             ctl_dec;
  logic [VOL_W-1:0] va_nx;
  logic [VOL_W-1:0] vb_nx;
  ctl_t             ctl_nx;

  assign is_ctl = frame[ADDR_BIT];
  assign wr_a   = frame[0];
  assign wr_b   = frame[1];
  assign code   = frame[VOL_W+1:2];

  assign ctl_dec = '{mode: frame[0], boost: frame[1], pwr: frame[2],
                     mute: frame[3], p1: frame[4], p2: frame[5]};

  always_comb begin
    va_nx  = vol_a;
    vb_nx  = vol_b;
    ctl_nx = ctl_q;
    if (clr) begin
      va_nx  = VOL_DEFAULT;
      vb_nx  = VOL_DEFAULT;
      ctl_nx = CTL_DEFAULT;
    end else if (wr_pulse) begin
      if (is_ctl) begin
        ctl_nx = ctl_dec;
      end else begin
        if (wr_a) va_nx = code;
        if (wr_b) vb_nx = code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_a   <= VOL_DEFAULT;
      vol_b   <= VOL_DEFAULT;
      ctl_q   <= CTL_DEFAULT;
      pwr_en  <= 1'b0;
      mute_on <= 1'b1;
    end else begin
      vol_a   <= va_nx;
      vol_b   <= vb_nx;
      ctl_q   <= ctl_nx;
      pwr_en  <= ctl_nx.pwr & pwr_pin_s;
      mute_on <= ctl_nx.mute | mute_pin_s;
    end
  end

endmodule

// File: rtl/ser_ctl_bank.sv
`timescale 1ns/1ps
module ser_ctl_bank
  import ser_ctl_pkg::*;
#(
  parameter int VOL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_stb,
  input  logic             pwr_pin,
  input  logic             mute_pin,
  output logic [VOL_W-1:0] vol_a,
  output logic [VOL_W-1:0] vol_b,
  output logic             mode_sel,
  output logic             boost_en,
  output logic             pwr_en,
  output logic             mute_on,
  output logic             port_p1,
  output logic             port_p2
);

  localparam int FRAME_W = VOL_W + 3;
  localparam int N_SYNC  = 6;
  localparam logic [FRAME_W-1:0] RST_FRAME = {1'b0, {VOL_W{1'b1}}, 2'b11};

  logic [N_SYNC-1:0]  raw_in;
  logic [N_SYNC-1:0]  sync_out;
  logic               cmd_ok;
  logic               sck_s;
  logic               sdi_s;
  logic               stb_s;
  logic               pwr_pin_s;
  logic               mute_pin_s;
  logic [FRAME_W-1:0] frame;
  logic               wr_pulse;
  ctl_t               ctl_q;

  assign raw_in = {cmd_rst_n, ser_clk, ser_dat, ser_stb, pwr_pin, mute_pin};
  assign {cmd_ok, sck_s, sdi_s, stb_s, pwr_pin_s, mute_pin_s} = sync_out;

  ssync #(
    .W      (N_SYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b100000)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (sync_out)
  );

  ser_shifter #(
    .FRAME_W  (FRAME_W),
    .RST_FRAME(RST_FRAME)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr     (~cmd_ok),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .stb_s   (stb_s),
    .frame   (frame),
    .wr_pulse(wr_pulse)
  );

  ctl_regfile #(
    .VOL_W(VOL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .clr       (~cmd_ok),
    .wr_pulse  (wr_pulse),
    .frame     (frame),
    .pwr_pin_s (pwr_pin_s),
    .mute_pin_s(mute_pin_s),
    .vol_a     (vol_a),
    .vol_b     (vol_b),
    .ctl_q     (ctl_q),
    .pwr_en    (pwr_en),
    .mute_on   (mute_on)
  );

  assign mode_sel = ctl_q.mode;
  assign boost_en = ctl_q.boost;
  assign port_p1  = ctl_q.p1;
  assign port_p2  = ctl_q.p2;

endmodule

// File: rtl/ser_ctl_bank_chk.sv
`timescale 1ns/1ps
module ser_ctl_bank_chk #(
  parameter int VOL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ok,
  input logic             wr_pulse,
  input logic             pwr_pin_s,
  input logic             mute_pin_s,
  input logic [VOL_W-1:0] vol_a,
  input logic [VOL_W-1:0] vol_b,
  input logic             mode_sel,
  input logic             boost_en,
  input logic             pwr_en,
  input logic             mute_on,
  input logic             port_p1,
  input logic             port_p2
);

  AST_VOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && !wr_pulse) |=> ($stable(vol_a) && $stable(vol_b))); // R5

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && !wr_pulse) |=> ($stable(mode_sel) && $stable(boost_en) &&
                               $stable(port_p1) && $stable(port_p2))); // R5

  AST_PWR_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
    pwr_en |-> $past(pwr_pin_s)); // R6

  AST_MUTE_PIN_FORCES: assert property (@(posedge clk) disable iff (rst)
    mute_pin_s |=> mute_on); // R7

  AST_CMD_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    !cmd_ok |=> (vol_a == '1 && vol_b == '1 && !mode_sel && !boost_en &&
                 !pwr_en && mute_on && port_p1 && !port_p2)); // R8

endmodule

bind ser_ctl_bank ser_ctl_bank_chk #(.VOL_W(VOL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ok    (cmd_ok),
  .wr_pulse  (wr_pulse),
  .pwr_pin_s (pwr_pin_s),
  .mute_pin_s(mute_pin_s),
  .vol_a     (vol_a),
  .vol_b     (vol_b),
  .mode_sel  (mode_sel),
  .boost_en  (boost_en),
  .pwr_en    (pwr_en),
  .mute_on   (mute_on),
  .port_p1   (port_p1),
  .port_p2   (port_p2)
);

// File: tb/ser_ctl_bank_tb.sv
`timescale 1ns/1ps
module ser_ctl_bank_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_rst_n = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_stb = 1'b0;
  logic       pwr_pin = 1'b0;
  logic       mute_pin = 1'b0;
  logic [5:0] vol_a, vol_b;
  logic       mode_sel, boost_en, pwr_en, mute_on, port_p1, port_p2;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  // reference state
  logic [5:0] rv_a, rv_b;
  logic       r_mode, r_bst, r_pwr, r_mute, r_p1, r_p2;

  always #2.5 clk = ~clk;

  ser_ctl_bank u_dut (
    .clk(clk), .rst(rst), .cmd_rst_n(cmd_rst_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .pwr_pin(pwr_pin), .mute_pin(mute_pin),
    .vol_a(vol_a), .vol_b(vol_b), .mode_sel(mode_sel), .boost_en(boost_en),
    .pwr_en(pwr_en), .mute_on(mute_on), .port_p1(port_p1), .port_p2(port_p2)
  );

  function automatic logic [8:0] vol_frame(input logic a, input logic b,
                                           input logic [5:0] code);
    return {1'b0, code, b, a};
  endfunction

  function automatic logic [8:0] ctl_frame(input logic [5:0] f, input logic [1:0] junk);
    // f[0]=mode f[1]=boost f[2]=pwr f[3]=mute f[4]=p1 f[5]=p2
    return {1'b1, junk, f};
  endfunction

  function automatic logic exp_pwr();
    return r_pwr & pwr_pin;
  endfunction

  function automatic logic exp_mute();
    return r_mute | mute_pin;
  endfunction

  task automatic ref_defaults();
    rv_a = 6'd63; rv_b = 6'd63;
    r_mode = 0; r_bst = 0; r_pwr = 0; r_mute = 1; r_p1 = 1; r_p2 = 0;
  endtask

  task automatic ref_apply(input logic [8:0] f);
    if (f[8]) begin
      r_mode = f[0]; r_bst = f[1]; r_pwr = f[2];
      r_mute = f[3]; r_p1 = f[4]; r_p2 = f[5];
    end else begin
      if (f[0]) rv_a = f[7:2];
      if (f[1]) rv_b = f[7:2];
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "vol_a",    {2'b0, vol_a}, {2'b0, rv_a});
    chk(tag, "vol_b",    {2'b0, vol_b}, {2'b0, rv_b});
    chk(tag, "mode_sel", {7'b0, mode_sel}, {7'b0, r_mode});
    chk(tag, "boost_en", {7'b0, boost_en}, {7'b0, r_bst});
    chk(tag, "pwr_en",   {7'b0, pwr_en},  {7'b0, exp_pwr()});
    chk(tag, "mute_on",  {7'b0, mute_on}, {7'b0, exp_mute()});
    chk(tag, "port_p1",  {7'b0, port_p1}, {7'b0, r_p1});
    chk(tag, "port_p2",  {7'b0, port_p2}, {7'b0, r_p2});
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift a frame first bit first; pins take new levels on the strobe-rise clock
  task automatic send(input logic [8:0] f, input bit strobe,
                      input logic new_pwr, input logic new_mute);
    for (int i = 0; i < 9; i++) begin
      ser_dat = f[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(3);
    pwr_pin  = new_pwr;
    mute_pin = new_mute;
    if (strobe) begin
      ser_stb = 1'b1;
      ref_apply(f);
      wait_clk(6);
      ser_stb = 1'b0;
    end
    wait_clk(10);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] f;
    void'($urandom(32'd2024));
    ref_defaults();
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    check_all("R8 reset");

    // R2: qualifiers 00 write nothing
    send(vol_frame(1'b0, 1'b0, 6'd5), 1'b1, 1'b0, 1'b0);
    check_all("R2 no-qual");
    // R2: channel A only, R1 address 0 path
    send(vol_frame(1'b1, 1'b0, 6'd10), 1'b1, 1'b0, 1'b0);
    check_all("R2 A-only");
    send(vol_frame(1'b0, 1'b1, 6'd33), 1'b1, 1'b0, 1'b0);
    check_all("R2 B-only");
    // R3: both channels, LSB/MSB positions
    send(vol_frame(1'b1, 1'b1, 6'b100001), 1'b1, 1'b0, 1'b0);
    check_all("R3 both");
    // R4/R9: control frame, junk bits set must be ignored; R1 address 1
    send(ctl_frame(6'b010101, 2'b11), 1'b1, 1'b1, 1'b0);
    check_all("R4 ctl-junk");
    send(ctl_frame(6'b101010, 2'b10), 1'b1, 1'b1, 1'b0);
    check_all("R9 ports");
    // R5: full frame without strobe changes nothing
    send(vol_frame(1'b1, 1'b1, 6'd0), 1'b0, 1'b1, 1'b0);
    check_all("R5 no-strobe");
    send(ctl_frame(6'b111111, 2'b00), 1'b0, 1'b1, 1'b0);
    check_all("R5 no-strobe-ctl");

    // R6/R7 same-cycle pin change and command write
    send(ctl_frame(6'b000000, 2'b00), 1'b1, 1'b1, 1'b1);
    check_all("R7 cmd0-pin1");
    send(ctl_frame(6'b001100, 2'b00), 1'b1, 1'b1, 1'b0);
    check_all("R7 cmd1-pin0");
    send(ctl_frame(6'b000000, 2'b00), 1'b1, 1'b0, 1'b0);
    check_all("R6 both-low");
    send(ctl_frame(6'b000100, 2'b00), 1'b1, 1'b0, 1'b0);
    check_all("R6 pin-low");
    send(ctl_frame(6'b000000, 2'b00), 1'b1, 1'b1, 1'b0);
    check_all("R6 cmd-low");

    // R8: command reset
    cmd_rst_n = 1'b0;
    wait_clk(6);
    ref_defaults();
    check_all("R8 cmdrst-held");
    cmd_rst_n = 1'b1;
    wait_clk(6);
    check_all("R8 cmdrst-released");

    // random frames, R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 60; k++) begin
      f = 9'($urandom());
      send(f, ($urandom() % 10) != 0, 1'($urandom()), 1'($urandom()));
      check_all("R1 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule